// File: doc/BRIEF.md
# Bit-Serial SIMD Memory-Column Processor Slice

This block is one slice of a processor-in-memory array. It contains a word-organised SRAM of `ROWS` rows, each `COLS` bits wide, and one single-bit processing element per column. A command is broadcast to the slice. It carries a row address, an opcode, an operand source and a mask-enable flag, and every element carries out that command on its own column of the addressed row in the same clock cycle. No element has a private address: all elements work on the same row.

Each element holds three one-bit registers: an accumulator, a carry and a write mask. In any cycle an element either reads its memory bit as an operand or writes the accumulator or carry back to its memory bit. It never does both. The elements form a linear chain, so an accumulator bit can move one column per cycle in either direction. The chain ends are brought out as ports so that slices can be joined. A wired-OR of all accumulators is reported at the slice boundary, and a partitioned OR over fixed groups of columns is available to the elements as an operand. A host port reads and writes whole rows while no command is active.

Top module: `pim_slice`

## Requirements
- R1: With `cmd_valid` low, `host_we` high writes `host_wdata` into row `host_addr`. `host_rdata` shows the contents of row `host_addr` one clock after the address is presented.
- R2: A command with `cmd_valid` high acts on row `cmd_row` in every column in the same cycle. Opcode 1 loads the operand into the accumulator. Opcode 2 ANDs the operand into the accumulator, opcode 3 ORs it in, and opcode 4 XORs it in. Opcode 0 does nothing.
- R3: Opcode 6 writes the accumulator and opcode 11 writes the carry into the element's bit of row `cmd_row`, and both leave the accumulator and carry unchanged. No other opcode writes memory.
- R4: Opcode 5 is a full-adder step. The accumulator becomes acc^op^carry and the carry becomes the majority of the three. Opcode 10 clears the carry.
- R5: Opcode 7 loads the operand into the element's mask. When `cmd_mask_en` is 1, a store changes only the columns whose mask is 1. When it is 0, a store changes every column.
- R6: Opcode 8 shifts the accumulators toward column 0, and column COLS-1 takes `right_in`. Opcode 9 shifts toward column COLS-1, and column 0 takes `left_in`. Shifts happen whatever the mask holds. `left_out` is the accumulator of column 0 and `right_out` is the accumulator of column COLS-1.
- R7: `cmd_src` selects the operand. 0 selects the memory bit of row `cmd_row`. 1 selects the accumulator of the lower-numbered neighbour, with `left_in` feeding column 0. 2 selects the global OR of all accumulators. 3 selects the OR of the accumulators in the element's group of `PART` adjacent columns. All operands are taken before the edge that updates them.
- R8: `glob_or` is the OR of all accumulators.
- R9: A host write in a cycle with `cmd_valid` high is ignored, and `host_err` is 1 for the following cycle. In every other case `host_err` is 0.
- R10: After reset all accumulators, carries and masks are 0 and `host_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Broadcast command present this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_src | input | 2 | Operand source select |
| cmd_row | input | $clog2(ROWS) | Shared row address |
| cmd_mask_en | input | 1 | Gate stores by per-element mask |
| host_we | input | 1 | Host row write |
| host_addr | input | $clog2(ROWS) | Host row address |
| host_wdata | input | COLS | Host write data |
| host_rdata | output | COLS | Registered host read data |
| host_err | output | 1 | Host write collided with a command |
| left_in | input | 1 | Chain input at column 0 |
| right_in | input | 1 | Chain input at column COLS-1 |
| left_out | output | 1 | Accumulator of column 0 |
| right_out | output | 1 | Accumulator of column COLS-1 |
| glob_or | output | 1 | OR of all accumulators |

## Verification
The bench builds the slice with COLS=8, ROWS=16 and PART=4. With this size it can write and read back every row, and it can run every logic and add opcode against every row. Two partitions of four columns make the partitioned OR differ from the global OR. Eight columns keep the chain short enough to push bits in from both ends and watch them arrive at the opposite port.

// File: rtl/pim_pkg.sv
package pim_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LDA = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_ADD = 4'd5,
        OP_STA = 4'd6,
        OP_LDM = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_CLC = 4'd10,
        OP_STC = 4'd11
    } pim_op_e;

    typedef enum logic [1:0] {
        SRC_MEM  = 2'd0,
        SRC_LEFT = 2'd1,
        SRC_GOR  = 2'd2,
        SRC_POR  = 2'd3
    } pim_src_e;

    typedef struct packed {
        logic acc;
        logic cry;
        logic msk;
    } pe_state_t;

endpackage

// File: rtl/pim_pe.sv
module pim_pe
    import pim_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pim_op_e  op,
    input  pim_src_e src,
    input  logic     mask_en,
    input  logic     mem_bit,
    input  logic     lft_bit,
    input  logic     rgt_bit,
    input  logic     gor_bit,
    input  logic     por_bit,
    output logic     acc,
    output logic     cry,
    output logic     msk,
    output logic     wr_en,
    output logic     st_bit
);

    pe_state_t st_d, st_q;
    logic      opnd;
    logic      is_store;

    always_comb begin
        unique case (src)
            SRC_MEM:  opnd = mem_bit;
            SRC_LEFT: opnd = lft_bit;
            SRC_GOR:  opnd = gor_bit;
            default:  opnd = por_bit;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LDA: st_d.acc = opnd;
            OP_AND: st_d.acc = st_q.acc & opnd;
            OP_OR:  st_d.acc = st_q.acc | opnd;
            OP_XOR: st_d.acc = st_q.acc ^ opnd;
            OP_ADD: begin
                st_d.acc = st_q.acc ^ opnd ^ st_q.cry;
                st_d.cry = (st_q.acc & opnd) | (st_q.cry & (st_q.acc ^ opnd));
            end
            OP_LDM: st_d.msk = opnd;
            OP_SHL: st_d.acc = rgt_bit;
            OP_SHR: st_d.acc = lft_bit;
            OP_CLC: st_d.cry = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_store = (op == OP_STA) || (op == OP_STC);
    assign wr_en    = is_store && (!mask_en || st_q.msk);
    assign st_bit   = (op == OP_STC) ? st_q.cry : st_q.acc;
    assign acc      = st_q.acc;
    assign cry      = st_q.cry;
    assign msk      = st_q.msk;

    // R3: a store cycle never alters the element registers
    a_r3_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        is_store |=> ($stable(st_q.acc) && $stable(st_q.cry)));

    // R4: clearing the carry
    a_r4_clc: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLC) |=> !st_q.cry);

    // R6: shift toward column 0 takes the right-hand bit
    a_r6_shl: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHL) |=> (st_q.acc == $past(rgt_bit)));

    // R5: mask load captures the selected operand
    a_r5_ldm: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LDM) |=> (st_q.msk == $past(opnd)));

endmodule

// File: rtl/pim_or_net.sv
module pim_or_net #(
    parameter int COLS = 64,
    parameter int PART = 8
) (
    input  logic [COLS-1:0] acc,
    output logic            gor,
    output logic [COLS-1:0] por
);

    localparam int NGRP = COLS / PART;

    logic [NGRP-1:0] grp_or;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_or[g] = |acc[g*PART +: PART];
        for (genvar k = 0; k < PART; k++) begin : g_fan
            assign por[g*PART + k] = grp_or[g];
        end
    end

    assign gor = |grp_or;

endmodule

// File: rtl/pim_sram.sv
module pim_sram #(
    parameter int COLS = 64,
    parameter int ROWS = 2048,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            host_we,
    input  logic [RW-1:0]   host_addr,
    input  logic [COLS-1:0] host_wdata,
    output logic [COLS-1:0] host_rdata,
    input  logic [RW-1:0]   row,
    output logic [COLS-1:0] row_word,
    input  logic [COLS-1:0] wr_bits,
    input  logic [COLS-1:0] wr_data
);

    logic [COLS-1:0] mem [ROWS];
    logic [COLS-1:0] rdata_q;

    assign row_word   = mem[row];
    assign host_rdata = rdata_q;

    always_ff @(posedge clk) begin
        rdata_q <= mem[host_addr];
        if (host_we)
            mem[host_addr] <= host_wdata;
        else if (|wr_bits)
            mem[row] <= (mem[row] & ~wr_bits) | (wr_data & wr_bits);
    end

    // R9: host writes and element stores never share a cycle
    a_r9_one_writer: assert property (@(posedge clk)
        !(host_we && (|wr_bits)));

endmodule

// File: rtl/pim_slice.sv
module pim_slice
    import pim_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 2048,
    parameter int PART = 8,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic [1:0]      cmd_src,
    input  logic [RW-1:0]   cmd_row,
    input  logic            cmd_mask_en,
    input  logic            host_we,
    input  logic [RW-1:0]   host_addr,
    input  logic [COLS-1:0] host_wdata,
    output logic [COLS-1:0] host_rdata,
    output logic            host_err,
    input  logic            left_in,
    input  logic            right_in,
    output logic            left_out,
    output logic            right_out,
    output logic            glob_or
);

    typedef struct packed {
        logic err;
    } top_state_t;

    top_state_t ts_d, ts_q;

    pim_op_e         op_eff;
    pim_src_e        src_eff;
    logic            host_we_ok;
    logic [COLS-1:0] acc_v, cry_v, msk_v, wr_v, st_v, por_v, row_word;
    logic            gor;

    assign op_eff     = cmd_valid ? pim_op_e'(cmd_op) : OP_NOP;
    assign src_eff    = pim_src_e'(cmd_src);
    assign host_we_ok = host_we && !cmd_valid;

    always_comb begin
        ts_d     = ts_q;
        ts_d.err = host_we && cmd_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    pim_or_net #(.COLS(COLS), .PART(PART)) u_or (
        .acc (acc_v),
        .gor (gor),
        .por (por_v)
    );

    pim_sram #(.COLS(COLS), .ROWS(ROWS)) u_mem (
        .clk        (clk),
        .host_we    (host_we_ok),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .row        (cmd_row),
        .row_word   (row_word),
        .wr_bits    (wr_v),
        .wr_data    (st_v)
    );

    for (genvar i = 0; i < COLS; i++) begin : g_pe
        logic lft, rgt;
        if (i == 0) begin : g_l0
            assign lft = left_in;
        end else begin : g_ln
            assign lft = acc_v[i-1];
        end
        if (i == COLS-1) begin : g_rn
            assign rgt = right_in;
        end else begin : g_r
            assign rgt = acc_v[i+1];
        end

        pim_pe u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op_eff),
            .src     (src_eff),
            .mask_en (cmd_mask_en),
            .mem_bit (row_word[i]),
            .lft_bit (lft),
            .rgt_bit (rgt),
            .gor_bit (gor),
            .por_bit (por_v[i]),
            .acc     (acc_v[i]),
            .cry     (cry_v[i]),
            .msk     (msk_v[i]),
            .wr_en   (wr_v[i]),
            .st_bit  (st_v[i])
        );
    end

    assign host_err  = ts_q.err;
    assign left_out  = acc_v[0];
    assign right_out = acc_v[COLS-1];
    assign glob_or   = gor;

    // R9: collision flag follows a host write during a command
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && host_we) |=> host_err);

    a_r9_err_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && host_we) |=> !host_err);

    // R8: global OR agrees with the partition ORs
    a_r8_gor_part: assert property (@(posedge clk) disable iff (!rst_n)
        glob_or == (|por_v));

    // R5: masked-off columns are never written
    a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mask_en |-> ((wr_v & ~msk_v) == '0));

    // R10: carry and mask start cleared
    a_r10_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (cry_v == '0 && msk_v == '0));

endmodule

// File: tb/pim_slice_tb.sv
module pim_slice_tb;

    localparam int C  = 8;
    localparam int R  = 16;
    localparam int P  = 4;
    localparam int RW = $clog2(R);
    localparam int SCR = R - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic cmd_valid = 0;
    logic [3:0] cmd_op = 0;
    logic [1:0] cmd_src = 0;
    logic [RW-1:0] cmd_row = 0;
    logic cmd_mask_en = 0;
    logic host_we = 0;
    logic [RW-1:0] host_addr = 0;
    logic [C-1:0] host_wdata = 0;
    logic [C-1:0] host_rdata;
    logic host_err;
    logic left_in = 0, right_in = 0;
    logic left_out, right_out, glob_or;

    int checks = 0;
    int fails  = 0;

    logic [C-1:0] ma = 0, mc = 0, mm = 0;
    logic [C-1:0] mmem [R];

    always #10 clk = ~clk;

    pim_slice #(.COLS(C), .ROWS(R), .PART(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_row(cmd_row), .cmd_mask_en(cmd_mask_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_err(host_err), .left_in(left_in),
        .right_in(right_in), .left_out(left_out), .right_out(right_out),
        .glob_or(glob_or)
    );

    function automatic logic [C-1:0] pat(int r);
        return C'((r * 29 + 7) ^ (r << 3) ^ 8'h5A);
    endfunction

    task automatic chk(string req, logic [C-1:0] act, logic [C-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [3:0] op, input logic [1:0] src,
                          input int row, input logic men);
        logic [C-1:0] x, na, nc, nm;
        for (int i = 0; i < C; i++) begin
            case (src)
                2'd0: x[i] = mmem[row][i];
                2'd1: x[i] = (i == 0) ? left_in : ma[i-1];
                2'd2: x[i] = |ma;
                default: x[i] = |ma[(i/P)*P +: P];
            endcase
        end
        na = ma; nc = mc; nm = mm;
        for (int i = 0; i < C; i++) begin
            case (op)
                4'd1: na[i] = x[i];
                4'd2: na[i] = ma[i] & x[i];
                4'd3: na[i] = ma[i] | x[i];
                4'd4: na[i] = ma[i] ^ x[i];
                4'd5: begin
                    na[i] = ma[i] ^ x[i] ^ mc[i];
                    nc[i] = (ma[i] + x[i] + mc[i]) >= 2;
                end
                4'd7: nm[i] = x[i];
                4'd8: na[i] = (i == C-1) ? right_in : ma[i+1];
                4'd9: na[i] = (i == 0) ? left_in : ma[i-1];
                4'd10: nc[i] = 1'b0;
                4'd6, 4'd11: if (!men || mm[i])
                    mmem[row][i] = (op == 4'd6) ? ma[i] : mc[i];
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_src = src;
        cmd_row = RW'(row); cmd_mask_en = men;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
        ma = na; mc = nc; mm = nm;
    endtask

    task automatic host_wr(int row, logic [C-1:0] d);
        @(negedge clk);
        host_we = 1; host_addr = RW'(row); host_wdata = d;
        @(negedge clk);
        host_we = 0;
        mmem[row] = d;
    endtask

    task automatic host_rd(string req, int row);
        @(negedge clk);
        host_addr = RW'(row);
        @(negedge clk);
        chk(req, host_rdata, mmem[row]);
    endtask

    // stores accumulator to scratch row, reads back (R3 store path)
    task automatic chk_acc(string req);
        chk({req, " R8 glob_or"}, C'(glob_or), C'(|ma));
        chk({req, " left_out/right_out"}, C'({right_out, left_out}), C'({ma[C-1], ma[0]}));
        do_cmd(4'd6, 2'd0, SCR, 1'b0);
        host_rd({req, " acc via R3 store"}, SCR);
    endtask

    task automatic chk_cry(string req);
        do_cmd(4'd11, 2'd0, SCR, 1'b0);
        host_rd({req, " carry via R3 store"}, SCR);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < R; r++) mmem[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        chk("R10 glob_or", C'(glob_or), 0);
        chk("R10 host_err", C'(host_err), 0);
        chk("R10 chain outputs", C'({right_out, left_out}), 0);

        // R1 write and read back every row
        for (int r = 0; r < R; r++) host_wr(r, pat(r));
        for (int r = 0; r < R; r++) host_rd("R1 readback", r);

        chk_acc("R10 acc");
        chk_cry("R10 carry");

        // R2 logic ops over every row with memory operand
        for (int r = 0; r < SCR; r++) begin
            for (int op = 1; op <= 4; op++) begin
                do_cmd(4'(op), 2'd0, r, 1'b0);
                chk_acc("R2 logic op");
            end
        end

        // R3 a load does not write memory; store keeps acc
        do_cmd(4'd1, 2'd0, 3, 1'b0);
        host_rd("R3 load leaves row", 3);
        do_cmd(4'd6, 2'd0, 4, 1'b0);
        host_rd("R3 store row", 4);
        chk_acc("R3 acc after store");

        // R4 bit-serial add over row pairs
        for (int r = 0; r < SCR - 1; r++) begin
            do_cmd(4'd10, 2'd0, 0, 1'b0);
            do_cmd(4'd1, 2'd0, r, 1'b0);
            do_cmd(4'd5, 2'd0, r + 1, 1'b0);
            do_cmd(4'd5, 2'd0, r + 1, 1'b0);
            chk_acc("R4 sum");
            chk_cry("R4 carry");
        end
        do_cmd(4'd10, 2'd0, 0, 1'b0);
        chk_cry("R4 clear carry");

        // R5 masked stores
        for (int r = 0; r < 6; r++) begin
            do_cmd(4'd7, 2'd0, r, 1'b0);
            do_cmd(4'd1, 2'd0, r + 6, 1'b0);
            do_cmd(4'd6, 2'd0, 13, 1'b1);
            host_rd("R5 masked store", 13);
            do_cmd(4'd11, 2'd0, 12, 1'b1);
            host_rd("R5 masked carry store", 12);
        end
        do_cmd(4'd6, 2'd0, 13, 1'b0);
        host_rd("R5 unmasked store", 13);

        // R7 operand sources
        for (int r = 0; r < 8; r++) begin
            left_in = r[0];
            do_cmd(4'd1, 2'd0, r, 1'b0);
            do_cmd(4'd1, 2'd1, 0, 1'b0);
            chk_acc("R7 left neighbour");
            do_cmd(4'd1, 2'd0, r, 1'b0);
            do_cmd(4'd1, 2'd3, 0, 1'b0);
            chk_acc("R7 partition OR");
            do_cmd(4'd1, 2'd0, r + 2, 1'b0);
            do_cmd(4'd4, 2'd2, 0, 1'b0);
            chk_acc("R7 global OR");
        end
        host_wr(11, 8'h10);
        do_cmd(4'd1, 2'd0, 11, 1'b0);
        do_cmd(4'd1, 2'd3, 0, 1'b0);
        chk_acc("R7 one group only");

        // R6 shifts with all masks zero
        host_wr(10, 8'h00);
        do_cmd(4'd7, 2'd0, 10, 1'b0);
        do_cmd(4'd1, 2'd0, 10, 1'b0);
        for (int s = 0; s < C + 2; s++) begin
            left_in = s[0];
            do_cmd(4'd9, 2'd0, 0, 1'b0);
            chk_acc("R6 shift toward high column");
        end
        for (int s = 0; s < C + 2; s++) begin
            right_in = (s % 3) == 0;
            do_cmd(4'd8, 2'd0, 0, 1'b0);
            chk_acc("R6 shift toward column 0");
        end
        right_in = 0; left_in = 0;

        // R9 host write during a command
        @(negedge clk);
        cmd_valid = 1; cmd_op = 4'd0;
        host_we = 1; host_addr = 3; host_wdata = ~mmem[3];
        @(negedge clk);
        cmd_valid = 0; host_we = 0;
        chk("R9 err raised", C'(host_err), 1);
        @(negedge clk);
        chk("R9 err cleared", C'(host_err), 0);
        host_rd("R9 write ignored", 3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule